// File: doc/BRIEF.md
# Shared Prescaler and Divider Tick Generator

This block turns one peripheral clock into count-enable strobes for a five-channel timer. Two 8-bit prescalers divide the clock first. The first prescaler feeds channels 0 and 1, and the second feeds channels 2, 3 and 4. Each channel then applies its own power-of-two divider to the pulses of its prescaler. Every channel output is a single-cycle tick strobe. The down counters that consume these strobes sit outside the block.

Configuration arrives as two 32-bit words, each with its own write strobe. The block keeps the fields it uses. Any configuration write restarts every prescaler and divider, so after a write the phase of every channel is known. The `DIV_BASE` parameter sets the divider encoding. With an offset of 1, the smallest divisor is 2. With an offset of 0, the smallest divisor is 1.

Top module: `timer_tick_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ch_tick` is all zero. Reset sets both prescaler fields and all selector fields to 0.
- R2: Bits [7:0] of word 0 hold prescale field A (value P). Channels 0 and 1 tick once every (P+1)×D clock cycles, where D is the channel's divisor.
- R3: Bits [15:8] of word 0 hold prescale field B. It sets the tick period of channels 2, 3 and 4 in the same way.
- R4: Channel n takes its selector code from bits [4n+3:4n] of word 1. The divisor is D = 2^(code+DIV_BASE). With the default DIV_BASE=1, code 0 gives D=2 and code 3 gives D=16.
- R5: If code+DIV_BASE is larger than MAX_SHIFT (default 4), the divisor is 2^MAX_SHIFT. With the defaults, codes 4 to 15 all give D=16.
- R6: A write to either word restarts all prescalers and dividers at the clock edge that takes the write. No tick appears in the next cycle. Counting n cycles from that edge, channel c ticks exactly when n>0 and n is a multiple of (P+1)×D.
- R7: Bits [31:16] of word 0 and bits [31:20] of word 1 have no effect on any tick.
- R8: Each tick is high for exactly one cycle. When DIV_BASE≥1, a channel never ticks in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pre_wr | input | 1 | Write strobe for word 0 (prescale fields) |
| cfg_pre_data | input | 32 | Word 0 data |
| cfg_sel_wr | input | 1 | Write strobe for word 1 (selector fields) |
| cfg_sel_data | input | 32 | Word 1 data |
| ch_tick | output | 5 | Per-channel single-cycle tick strobes |

## Verification
The bench first runs the reset defaults. With P=0 and divide-by-2, every channel alternates, which isolates one-cycle pulse width and the reset phase. Next it uses unequal prescalers with every selector code distinct. This separates the A and B groups and the divisor encoding. Codes above the supported range are then compared with code 3 to expose the clamp. The bench also writes only word 1 in the middle of a run, and later writes both words in the same cycle. These steps show that the restart realigns phase. Garbage in the unused upper bits must leave every period unchanged.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;

    // Maps a selector code to a divide shift, clamped to the largest supported ratio.
    function automatic int sel_shift(int code, int base, int max_sh);
        int s;
        s = code + base;
        return (s > max_sh) ? max_sh : s;
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRE_W-1:0] restart_val,
    input  logic [PRE_W-1:0] reload_val,
    output logic             pulse
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    assign pulse = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt = restart_val;
        end else if (pulse) begin
            st_d.cnt = reload_val;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= reload_val);

endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int MAX_SHIFT = 4,
    localparam int SHW = $clog2(MAX_SHIFT + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           pulse_in,
    input  logic [SHW-1:0] shift,
    output logic           tick
);
    typedef struct packed {
        logic [MAX_SHIFT-1:0] cnt;
        logic                 tick;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [MAX_SHIFT:0]   span;
    logic [MAX_SHIFT-1:0] mask;
    logic                 full;

    always_comb begin
        span = {{MAX_SHIFT{1'b0}}, 1'b1} << shift;
        mask = MAX_SHIFT'(span - {{MAX_SHIFT{1'b0}}, 1'b1});
        full = (st_q.cnt == mask);
        st_d = st_q;
        st_d.tick = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (pulse_in) begin
            if (full) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

    // R5
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= mask);

endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen #(
    parameter int NUM_CH    = 5,
    parameter int GRP_A_CH  = 2,
    parameter int PRE_W     = 8,
    parameter int SEL_W     = 4,
    parameter int CFG_W     = 32,
    parameter int DIV_BASE  = 1,
    parameter int MAX_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pre_wr,
    input  logic [CFG_W-1:0]  cfg_pre_data,
    input  logic              cfg_sel_wr,
    input  logic [CFG_W-1:0]  cfg_sel_data,
    output logic [NUM_CH-1:0] ch_tick
);
    localparam int NUM_GRP = 2;
    localparam int SHW     = $clog2(MAX_SHIFT + 1);

    typedef struct packed {
        logic [NUM_GRP-1:0][PRE_W-1:0] pre;
        logic [NUM_CH-1:0][SEL_W-1:0]  sel;
    } cfg_t;

    cfg_t                cfg_d, cfg_q;
    logic                restart;
    logic [NUM_GRP-1:0]  grp_pulse;
    logic                unused_cfg_bits;

    assign restart = cfg_pre_wr | cfg_sel_wr;
    assign unused_cfg_bits = ^{cfg_pre_data[CFG_W-1:NUM_GRP*PRE_W],
                               cfg_sel_data[CFG_W-1:NUM_CH*SEL_W]};

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_pre_wr) begin
            for (int g = 0; g < NUM_GRP; g++)
                cfg_d.pre[g] = cfg_pre_data[g*PRE_W +: PRE_W];
        end
        if (cfg_sel_wr) begin
            for (int c = 0; c < NUM_CH; c++)
                cfg_d.sel[c] = cfg_sel_data[c*SEL_W +: SEL_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_pre
        tick_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk         (clk),
            .rst_n       (rst_n),
            .restart     (restart),
            .restart_val (cfg_d.pre[g]),
            .reload_val  (cfg_q.pre[g]),
            .pulse       (grp_pulse[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int G = (c < GRP_A_CH) ? 0 : 1;
        logic [SHW-1:0] ch_shift;

        assign ch_shift = SHW'(tick_gen_pkg::sel_shift(int'(cfg_q.sel[c]), DIV_BASE, MAX_SHIFT));

        tick_divider #(.MAX_SHIFT(MAX_SHIFT)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (restart),
            .pulse_in (grp_pulse[G]),
            .shift    (ch_shift),
            .tick     (ch_tick[c])
        );

        // R2 R3
        tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_tick[c] |-> $past(grp_pulse[G]));

        if (DIV_BASE > 0) begin : g_sp
            // R8
            single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ch_tick[c] |=> !ch_tick[c]);
        end
    end

    // R6
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ch_tick == '0));

endmodule

// File: tb/timer_tick_gen_bench.sv
module timer_tick_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 5;
    localparam int GRP_A = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_pre_wr = 1'b0;
    logic [31:0] cfg_pre_data = '0;
    logic        cfg_sel_wr = 1'b0;
    logic [31:0] cfg_sel_data = '0;
    logic [NCH-1:0] ch_tick;

    int checks = 0;
    int failures = 0;
    string cur_req = "R8";

    // behavioural model state
    int n = 0;
    int pa = 0;
    int pb = 0;
    int sel_m [NCH];

    timer_tick_gen u_timer_tick_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_pre_wr   (cfg_pre_wr),
        .cfg_pre_data (cfg_pre_data),
        .cfg_sel_wr   (cfg_sel_wr),
        .cfg_sel_data (cfg_sel_data),
        .ch_tick      (ch_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int period_of(int c);
        int k;
        int pre;
        pre = ((c < GRP_A) ? pa : pb) + 1;
        k = sel_m[c] + 1;
        if (k > 4) k = 4;
        return pre * (1 << k);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            n = 0; pa = 0; pb = 0;
            for (int c = 0; c < NCH; c++) sel_m[c] = 0;
        end else if (cfg_pre_wr || cfg_sel_wr) begin
            n = 0;
            if (cfg_pre_wr) begin
                pa = int'(cfg_pre_data[7:0]);
                pb = int'(cfg_pre_data[15:8]);
            end
            if (cfg_sel_wr)
                for (int c = 0; c < NCH; c++) sel_m[c] = int'(cfg_sel_data[4*c +: 4]);
        end else begin
            n = n + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst_n || n == 0) begin
            checks++;
            if (ch_tick !== '0) begin
                failures++;
                $display("FAIL %s quiet ch_tick actual=%b expected=00000",
                         (!rst_n) ? "R1" : "R6", ch_tick);
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                logic exp_t;
                exp_t = ((n % period_of(c)) == 0);
                checks++;
                if (ch_tick[c] !== exp_t) begin
                    failures++;
                    $display("FAIL %s/%s ch%0d n=%0d actual=%b expected=%b",
                             (c < GRP_A) ? "R2" : "R3", cur_req, c, n, ch_tick[c], exp_t);
                end
            end
        end
    end

    task automatic write_cfg(input logic w0, input logic [31:0] d0,
                             input logic w1, input logic [31:0] d1);
        @(negedge clk);
        cfg_pre_wr = w0; cfg_pre_data = d0;
        cfg_sel_wr = w1; cfg_sel_data = d1;
        @(negedge clk);
        cfg_pre_wr = 1'b0; cfg_sel_wr = 1'b0;
    endtask

    task automatic run_stim();
        repeat (4) @(negedge clk);          // R1 checked during reset
        rst_n = 1'b1;
        cur_req = "R8";                     // defaults: period 2, alternating
        repeat (40) @(negedge clk);
        cur_req = "R4";                     // A=3, B=0; codes 0,1,2,3,7
        write_cfg(1'b1, 32'h0000_0003, 1'b1, {12'h000, 4'd7, 4'd3, 4'd2, 4'd1, 4'd0});
        repeat (300) @(negedge clk);
        cur_req = "R5";                     // clamp codes 4 and 15 vs code 3
        write_cfg(1'b1, 32'h0000_0409, 1'b1, {12'h000, 4'd3, 4'd1, 4'd0, 4'd15, 4'd4});
        repeat (333) @(negedge clk);
        cur_req = "R6";                     // selector-only write mid-run
        write_cfg(1'b0, 32'h0, 1'b1, {12'h000, 4'd0, 4'd2, 4'd1, 4'd0, 4'd1});
        repeat (217) @(negedge clk);
        write_cfg(1'b1, 32'h0000_0102, 1'b1, {12'h000, 4'd1, 4'd0, 4'd3, 4'd2, 4'd0});
        repeat (250) @(negedge clk);
        cur_req = "R7";                     // garbage in unused upper bits
        write_cfg(1'b1, 32'hDEAD_0201, 1'b1, {12'hFA5, 4'd2, 4'd1, 4'd0, 4'd1, 4'd2});
        repeat (300) @(negedge clk);
    endtask

    initial begin
        fork
            run_stim();
            begin
                repeat (200000) @(posedge clk);
                failures++;
                $display("FAIL R1 watchdog actual=timeout expected=finished");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule